// File: doc/BRIEF.md
# Video Ramp Packet Source

This block is a synthetic video source for bring-up of a streaming pixel pipeline. On each start pulse it produces one frame. The frame is sent as two packets on a streaming source port. The first is a short control packet that gives the frame width, the frame height and an interlace code. The second is a video packet that carries one pixel per beat, in raster order. Every row holds a horizontal ramp that counts up from 1 to the frame width and starts again at 1 on the next row. Because each row is this simple, any lost or repeated pixel shows up at once in a downstream capture.

The port follows a ready latency of one cycle. The source looks at ready on a clock edge and presents a beat in the following cycle only if ready was high. Every beat that is presented is therefore a transfer. The pattern counters move forward only when a beat is presented. A stall holds the next pixel, so a pixel is never skipped or repeated. Frame pacing comes from outside: the block waits in idle until a start pulse arrives and ignores any pulse that comes while a frame is still being sent.

Top module: `vrg_ramp_source`

## Requirements
- R1: A synchronous active-high reset returns the block to idle from any state. While reset is high and afterwards, `st_valid`, `st_sop` and `st_eop` are 0. A frame that was cut off by reset is abandoned, and the next frame starts again from its first control beat.
- R2: In idle, no beat is presented, whatever the value of `st_ready`, until a cycle with `frame_start` high. One frame follows each such pulse.
- R3: A `frame_start` pulse that arrives while a frame is in progress has no effect. This includes the cycle in which the frame's final beat is issued. Once the frame ends, no further beat appears until a new pulse arrives in idle.
- R4: `st_valid` is high in a cycle only if `st_ready` was high in the cycle before.
- R5: Each cycle of the frame whose preceding cycle had `st_ready` high carries exactly the next beat of the frame. With `st_ready` held high, the frame's beats come out on consecutive cycles with no gap. A stall never drops a beat and never repeats one.
- R6: The first beat of the control packet has `st_sop` = 1 and data 0x000F (packet type 0xF in bits [3:0], all higher bits zero).
- R7: The control packet is 10 beats long. Beats 1 to 4 carry the 16-bit frame width, four bits per beat, most significant nibble first. Beats 5 to 8 carry the 16-bit frame height in the same way. Beat 9 carries the interlace code. Each nibble sits in bits [3:0] with zeros above it, and beat 9 alone has `st_eop` = 1.
- R8: The beat after the control packet opens the video packet, with `st_sop` = 1, `st_eop` = 0 and data 0x0000 (packet type 0x0).
- R9: The video pixels follow in raster order, one per beat. The pixel in column c (1-based) of every row has the value c, for c from 1 to FRAME_W. There are FRAME_H rows.
- R10: `st_eop` is 1 only on the pixel in the last column of the last row. The video packet is exactly 1 + FRAME_W*FRAME_H beats long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Starts one frame when the block is idle |
| st_ready | input | 1 | Sink ready; a beat may follow one cycle later |
| st_valid | output | 1 | Beat present; it always transfers |
| st_data | output | DATA_W | Beat data: packet type, control nibble or pixel value |
| st_sop | output | 1 | First beat of a packet |
| st_eop | output | 1 | Last beat of a packet |

## Verification
Two functions can fall on the same clock edge: the issue of a frame's final pixel and a new start pulse. The bench counts the beats it has seen. When exactly one beat remains, it raises `frame_start` together with `st_ready`, so the final beat and the pulse meet on that edge. After the end-of-packet beat, a quiet window must show no `st_valid` at all, which confirms the pulse was ignored. A second collision comes from random and alternating ready patterns. These patterns land stalls on the control-to-video packet boundary and on row wraps. Every beat is compared against a value the bench computes from its position in the frame.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  // Beats in the control packet: type beat + 4 width + 4 height + 1 interlace
  localparam int CTRL_BEATS = 10;
  localparam logic [3:0] TYPE_CTRL = 4'hF;
  localparam logic [3:0] TYPE_VIDEO = 4'h0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CTRL = 2'd1,
    PH_VID  = 2'd2
  } phase_e;
endpackage

// File: rtl/vrg_ctrl_encoder.sv
module vrg_ctrl_encoder
  import vrg_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter logic [3:0] INTERLACE = 4'h0
) (
  input  logic [3:0] idx,
  output logic [3:0] nibble
);
  localparam logic [15:0] W_FIELD = 16'(FRAME_W);
  localparam logic [15:0] H_FIELD = 16'(FRAME_H);
  // payload of beats 1..9, beat 1 in the top nibble
  localparam logic [35:0] PAYLOAD = {W_FIELD, H_FIELD, INTERLACE};

  logic [5:0] bitpos;

  always_comb begin
    bitpos = 6'd0;
    nibble = TYPE_CTRL;
    if (idx != 4'd0 && idx < 4'(CTRL_BEATS)) begin
      bitpos = 6'((4'(CTRL_BEATS - 1) - idx) * 4);
      nibble = PAYLOAD[bitpos +: 4];
    end
  end
endmodule

// File: rtl/vrg_pixel_counter.sv
module vrg_pixel_counter #(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  localparam int COL_W = $clog2(FRAME_W + 1),
  localparam int ROW_W = $clog2(FRAME_H + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             last_col,
  output logic             last_row
);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(FRAME_W);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(FRAME_H);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  assign last_col = (col == COL_MAX);
  assign last_row = (row == ROW_MAX);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      col <= COL_ONE;
      row <= ROW_ONE;
    end else if (step) begin
      if (last_col) begin
        col <= COL_ONE;
        row <= last_row ? ROW_ONE : row + ROW_ONE;
      end else begin
        col <= col + COL_ONE;
      end
    end
  end

  // R9: column stays inside 1..FRAME_W
  p_col_range_r9: assert property (@(posedge clk) disable iff (rst)
    (col != '0) && (col <= COL_MAX));

  // R9: a step inside a row moves exactly one column on
  p_col_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && !last_col) |=> (col == COL_W'($past(col) + 1'b1)));

  // R9: a row wrap returns to column 1
  p_row_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && last_col) |=> (col == COL_ONE));
endmodule

// File: rtl/vrg_sequencer.sv
module vrg_sequencer
  import vrg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ready,
  input  logic       last_pix,
  output phase_e     phase,
  output logic [3:0] ctrl_idx,
  output logic       vid_hdr,
  output logic       adv,
  output logic       pix_step,
  output logic       pix_clear
);
  localparam logic [3:0] CTRL_LAST = 4'(CTRL_BEATS - 1);

  // a beat is issued on every edge where ready is seen and a frame is open
  assign adv       = ready && (phase != PH_IDLE);
  assign pix_clear = (phase == PH_IDLE) && start;
  assign pix_step  = adv && (phase == PH_VID) && !vid_hdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      ctrl_idx <= 4'd0;
      vid_hdr  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_CTRL;
            ctrl_idx <= 4'd0;
          end
        end
        PH_CTRL: begin
          if (adv) begin
            if (ctrl_idx == CTRL_LAST) begin
              phase   <= PH_VID;
              vid_hdr <= 1'b1;
            end else begin
              ctrl_idx <= ctrl_idx + 4'd1;
            end
          end
        end
        PH_VID: begin
          if (adv) begin
            if (vid_hdr) vid_hdr <= 1'b0;
            else if (last_pix) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: idle holds without a start pulse
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

  // R3: a frame in its video phase never restarts its control packet
  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VID) |=> (phase != PH_CTRL));

  // R8: last control beat hands over to the video header
  p_ctrl_to_vid_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CTRL && ctrl_idx == CTRL_LAST && adv) |=> (phase == PH_VID && vid_hdr));
endmodule

// File: rtl/vrg_ramp_source.sv
module vrg_ramp_source
  import vrg_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int DATA_W = 16,
  parameter logic [3:0] INTERLACE = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              st_ready,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop
);
  localparam int COL_W = $clog2(FRAME_W + 1);
  localparam int ROW_W = $clog2(FRAME_H + 1);
  localparam logic [3:0] CTRL_LAST = 4'(CTRL_BEATS - 1);

  phase_e            phase;
  logic [3:0]        ctrl_idx;
  logic              vid_hdr;
  logic              adv;
  logic              pix_step;
  logic              pix_clear;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic              last_col;
  logic              last_row;
  logic [3:0]        ctrl_nib;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_sop;
  logic              nxt_eop;

  vrg_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (frame_start),
    .ready     (st_ready),
    .last_pix  (last_col && last_row),
    .phase     (phase),
    .ctrl_idx  (ctrl_idx),
    .vid_hdr   (vid_hdr),
    .adv       (adv),
    .pix_step  (pix_step),
    .pix_clear (pix_clear)
  );

  vrg_pixel_counter #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H)
  ) u_pix (
    .clk      (clk),
    .rst      (rst),
    .clear    (pix_clear),
    .step     (pix_step),
    .col      (col),
    .row      (row),
    .last_col (last_col),
    .last_row (last_row)
  );

  vrg_ctrl_encoder #(
    .FRAME_W   (FRAME_W),
    .FRAME_H   (FRAME_H),
    .INTERLACE (INTERLACE)
  ) u_enc (
    .idx    (ctrl_idx),
    .nibble (ctrl_nib)
  );

  // beat selection for the next issued beat
  always_comb begin
    nxt_data = '0;
    nxt_sop  = 1'b0;
    nxt_eop  = 1'b0;
    if (phase == PH_CTRL) begin
      nxt_data = DATA_W'(ctrl_nib);
      nxt_sop  = (ctrl_idx == 4'd0);
      nxt_eop  = (ctrl_idx == CTRL_LAST);
    end else if (phase == PH_VID) begin
      if (vid_hdr) begin
        nxt_data = DATA_W'(TYPE_VIDEO);
        nxt_sop  = 1'b1;
      end else begin
        nxt_data = DATA_W'(col);
        nxt_eop  = last_col && last_row;
      end
    end
  end

  // registered output stage: valid follows the ready seen on this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_data  <= '0;
      st_sop   <= 1'b0;
      st_eop   <= 1'b0;
    end else begin
      st_valid <= adv;
      if (adv) begin
        st_data <= nxt_data;
        st_sop  <= nxt_sop;
        st_eop  <= nxt_eop;
      end else begin
        st_sop <= 1'b0;
        st_eop <= 1'b0;
      end
    end
  end

  // R4: a beat only follows a cycle with ready high
  p_valid_after_ready_r4: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(st_ready));

  // R6: no packet opens and closes on the same beat
  p_sop_not_eop_r6: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_sop) |-> !st_eop);

  // R1: framing marks never appear without a beat
  p_marks_need_valid_r1: assert property (@(posedge clk) disable iff (rst)
    !st_valid |-> (!st_sop && !st_eop));
endmodule

// File: tb/sim_vrg_ramp_source.sv
`timescale 1ns/1ps
module sim_vrg_ramp_source;
  localparam int W = 640;
  localparam int H = 4;
  localparam int DW = 16;
  localparam logic [3:0] IL = 4'h3;
  localparam int TOTAL = 11 + W * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic st_ready = 1'b0;
  logic st_valid;
  logic [DW-1:0] st_data;
  logic st_sop;
  logic st_eop;

  int total = 0;
  int bad = 0;
  int beat = 0;
  bit active = 0;
  bit go = 0;
  bit coincide = 0;
  bit spur = 0;
  bit gapchk = 0;
  int mode = 1;
  int quiet_viol = 0;
  string quiet_tag = "R2";

  always #4 clk = ~clk;

  vrg_ramp_source #(.FRAME_W(W), .FRAME_H(H), .DATA_W(DW), .INTERLACE(IL)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .st_ready(st_ready),
    .st_valid(st_valid), .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {sop, eop, data} for beat b of a frame
  function automatic logic [DW+1:0] exp_beat(input int b);
    int p;
    if (b == 0) return {1'b1, 1'b0, DW'(4'hF)};
    if (b <= 4) return {2'b00, DW'((W >> (4 * (4 - b))) & 15)};
    if (b <= 8) return {2'b00, DW'((H >> (4 * (8 - b))) & 15)};
    if (b == 9) return {2'b01, DW'(IL)};
    if (b == 10) return {2'b10, DW'(0)};
    p = b - 11;
    return {1'b0, (p == W * H - 1), DW'(p % W + 1)};
  endfunction

  function automatic string beat_tag(input int b);
    if (b == 0) return "R6 ctrl type beat";
    if (b <= 9) return "R7 ctrl payload";
    if (b == 10) return "R8 video header";
    if (b == TOTAL - 1) return "R10 final pixel";
    return "R9 ramp pixel";
  endfunction

  // monitor and ready/start driver, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (st_valid) begin
        chk(st_ready, "R4 valid without prior ready", st_ready, 1);
        if (active) begin
          chk({st_sop, st_eop, st_data} == exp_beat(beat), beat_tag(beat),
              int'({st_sop, st_eop, st_data}), int'(exp_beat(beat)));
          beat++;
          if (beat == TOTAL) active = 0;
        end else begin
          quiet_viol++;
          chk(0, quiet_tag, 1, 0);
        end
      end else if (active && gapchk && beat > 0) begin
        chk(0, "R5 gap under full ready", 0, 1);
      end
    end
    frame_start = 1'b0;
    case (mode)
      0: st_ready = 1'($urandom % 2);
      1: st_ready = 1'b1;
      default: st_ready = ~st_ready;
    endcase
    if (go && !active && !rst) begin
      frame_start = 1'b1;
      active = 1;
      beat = 0;
      go = 0;
    end else if (active && coincide && beat == TOTAL - 1) begin
      frame_start = 1'b1;
      st_ready = 1'b1;
      coincide = 0;
    end else if (active && spur && ($urandom % 97 == 0)) begin
      frame_start = 1'b1;
    end
  end

  task automatic run_frame();
    go = 1;
    wait (go == 0);
    wait (active == 0);
  endtask

  task automatic quiet(input string tag, input int n);
    quiet_viol = 0;
    quiet_tag = tag;
    repeat (n) @(posedge clk);
    #1 chk(quiet_viol == 0, tag, quiet_viol, 0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", beat, TOTAL);
    finish_up();
  end

  initial begin
    // R1: outputs clear under reset
    repeat (4) @(posedge clk);
    #1 chk(!st_valid && !st_sop && !st_eop, "R1 reset outputs", st_valid, 0);
    rst = 1'b0;
    // R2: idle with ready high and no start
    quiet("R2 beat without start", 20);
    // random backpressure plus start pulses mid-frame (R3)
    mode = 0; spur = 1;
    run_frame();
    spur = 0;
    quiet("R3 beat after frame with ignored starts", 30);
    // full ready: contiguous beats (R5), start on the final beat edge (R3)
    mode = 1; gapchk = 1; coincide = 1;
    run_frame();
    gapchk = 0;
    chk(coincide == 0, "R3 collision not provoked", coincide, 0);
    quiet("R3 start on final beat restarted", 30);
    // alternating ready: stalls at every boundary (R5)
    mode = 2;
    run_frame();
    quiet("R10 beat after end of packet", 20);
    // reset mid-frame (R1)
    mode = 0;
    go = 1;
    wait (go == 0);
    wait (beat >= 100);
    @(posedge clk); #1 rst = 1'b1; active = 0;
    repeat (2) @(posedge clk);
    #1 chk(!st_valid && !st_sop && !st_eop, "R1 reset mid-frame", st_valid, 0);
    rst = 1'b0;
    quiet("R1 beat after mid-frame reset", 15);
    run_frame();
    quiet("R1 beat after fresh frame", 10);
    finish_up();
  end
endmodule